// File: doc/BRIEF.md
# Mixed-Signedness Fractional Byte Multiplier

This block multiplies two byte operands and returns a 16-bit product split into a high byte and a low byte, together with a zero flag and a carry flag. A 3-bit mode chooses how the operands are read. Both can be unsigned, both can be two's complement, or operand A can be two's complement while operand B is unsigned. Any of these can also run in fractional form. In fractional form the product is shifted left by one bit, which lines a 1.7-format result up as a 1.15 value.

A request is made by raising `start` for one cycle. The operands and the mode are captured in that cycle. The result, the flags and a one-cycle `done` pulse appear two cycles later. `busy` is high in the cycle between. A request made while `busy` is high is dropped. A request made in the same cycle as `done` is taken.

Top module: `fracmul8_unit`

## Requirements
- R1: While reset is held and after it is released, `done`, `busy`, both product bytes and both flags read zero until the first request completes.
- R2: Mode 3'b000 reads both operands as unsigned. `{prod_hi, prod_lo}` is the low 16 bits of the exact product.
- R3: Mode 3'b001 reads both operands as two's complement. `{prod_hi, prod_lo}` is the 16-bit two's complement product.
- R4: Mode 3'b010 reads operand A as two's complement and operand B as unsigned. `{prod_hi, prod_lo}` is the low 16 bits of that product.
- R5: Mode bit 2 selects fractional form. The result is then the 16-bit product of R2 to R4 shifted left by one, so bit 0 is zero and the top bit of the unshifted product is lost. Mode bits 1:0 = 2'b11 behave like 2'b00.
- R6: `flag_c` equals bit 15 of the unshifted 16-bit product.
- R7: `flag_z` is 1 exactly when the final 16-bit result, after any shift, is zero. It is always 1 when either operand is zero.
- R8: `done` is high for exactly one cycle, two cycles after the cycle in which a request was taken. `busy` is high in the cycle between, and `done` never follows a cycle in which nothing was taken.
- R9: A `start` raised while `busy` is high is ignored and produces no `done`. A `start` raised in the cycle `done` is high is taken.
- R10: The product bytes and flags change only in a cycle where `done` is high. They hold otherwise, whatever the operand and mode inputs do.
- R11: Operand and mode values are sampled only in the cycle a request is taken. Later changes do not alter that request's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply this cycle |
| op_a | input | 8 | Operand A (multiplicand) |
| op_b | input | 8 | Operand B (multiplier) |
| mode | input | 3 | Bit 2 fractional; bits 1:0 signedness (00 UU, 01 SS, 10 SU, 11 as UU) |
| prod_lo | output | 8 | Low byte of result |
| prod_hi | output | 8 | High byte of result |
| flag_z | output | 1 | Result-is-zero flag |
| flag_c | output | 1 | Bit 15 of the unshifted product |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A request is in flight; `start` is ignored |

## Verification
The bound checker watches the handshake on every cycle:
- the two-cycle spacing between a taken request and `done`;
- the single-cycle width of `done`;
- the dropping of a request made while busy;
- that results and flags stay unchanged away from `done`;
- that fractional results end in a zero bit;
- that a zero operand A forces Z high and C low.

The arithmetic itself is shown only by the bench's scenarios. These compare the product bytes and flags against a model for each signedness and for the fractional forms. They cover the cases where the three signedness readings of the same bit patterns give different answers, and the reserved signedness code. They also cover requests made back-to-back on `done` and operand changes made after a request was captured.

// File: rtl/fracmul8_pkg.sv
package fracmul8_pkg;

    localparam int MODE_W   = 3;
    localparam int FRAC_BIT = 2;

    // Signedness selection held in mode bits 1:0.
    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_RSV = 2'b11
    } sign_sel_e;

endpackage

// File: rtl/fracmul8_decode.sv
module fracmul8_decode
    import fracmul8_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              a_signed,
    output logic              b_signed,
    output logic              frac
);

    sign_sel_e sel;

    always_comb begin
        sel      = sign_sel_e'(mode[1:0]);
        frac     = mode[FRAC_BIT];
        a_signed = 1'b0;
        b_signed = 1'b0;
        case (sel)
            SGN_SS: begin
                a_signed = 1'b1;
                b_signed = 1'b1;
            end
            SGN_SU: begin
                a_signed = 1'b1;
                b_signed = 1'b0;
            end
            default: begin
                // unsigned, and the reserved code falls back to unsigned
                a_signed = 1'b0;
                b_signed = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fracmul8_sext.sv
module fracmul8_sext #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         is_signed,
    output logic [W:0]   ext
);

    // One guard bit lets a single signed multiplier serve every signedness.
    always_comb begin
        ext = {is_signed & val[W-1], val};
    end

endmodule

// File: rtl/fracmul8_core.sv
module fracmul8_core #(
    parameter int W = 8
) (
    input  logic [W:0]     a_x,
    input  logic [W:0]     b_x,
    input  logic           frac,
    output logic [2*W-1:0] result,
    output logic           carry,
    output logic           zero
);

    localparam int PW = 2 * W;
    localparam int FW = 2 * W + 2;

    logic signed [FW-1:0] full;
    logic [PW-1:0]        raw;
    logic                 unused_hi;

    always_comb begin
        full      = $signed(a_x) * $signed(b_x);
        raw       = full[PW-1:0];
        unused_hi = ^full[FW-1:PW];
        carry     = raw[PW-1];
        result    = frac ? {raw[PW-2:0], 1'b0} : raw;
        zero      = (result == '0);
    end

endmodule

// File: rtl/fracmul8_unit.sv
module fracmul8_unit
    import fracmul8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [MODE_W-1:0] mode,
    output logic [W-1:0]      prod_lo,
    output logic [W-1:0]      prod_hi,
    output logic              flag_z,
    output logic              flag_c,
    output logic              done,
    output logic              busy
);

    localparam int PW = 2 * W;
    localparam int XW = W + 1;

    typedef struct packed {
        logic          vld;
        logic [XW-1:0] a;
        logic [XW-1:0] b;
        logic          frac;
    } opnd_t;

    typedef struct packed {
        logic          done;
        logic [PW-1:0] res;
        logic          z;
        logic          c;
    } rslt_t;

    opnd_t s1_d, s1_q;
    rslt_t s2_d, s2_q;

    logic          a_signed, b_signed, frac_in;
    logic [XW-1:0] a_ext, b_ext;
    logic [PW-1:0] core_res;
    logic          core_c, core_z;
    logic          accept;

    fracmul8_decode u_decode (
        .mode     (mode),
        .a_signed (a_signed),
        .b_signed (b_signed),
        .frac     (frac_in)
    );

    fracmul8_sext #(.W(W)) u_sext_a (
        .val       (op_a),
        .is_signed (a_signed),
        .ext       (a_ext)
    );

    fracmul8_sext #(.W(W)) u_sext_b (
        .val       (op_b),
        .is_signed (b_signed),
        .ext       (b_ext)
    );

    fracmul8_core #(.W(W)) u_core (
        .a_x    (s1_q.a),
        .b_x    (s1_q.b),
        .frac   (s1_q.frac),
        .result (core_res),
        .carry  (core_c),
        .zero   (core_z)
    );

    always_comb begin
        accept   = start & ~s1_q.vld;

        s1_d     = s1_q;
        s1_d.vld = accept;
        if (accept) begin
            s1_d.a    = a_ext;
            s1_d.b    = b_ext;
            s1_d.frac = frac_in;
        end

        s2_d      = s2_q;
        s2_d.done = s1_q.vld;
        if (s1_q.vld) begin
            s2_d.res = core_res;
            s2_d.z   = core_z;
            s2_d.c   = core_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign prod_lo = s2_q.res[W-1:0];
    assign prod_hi = s2_q.res[PW-1:W];
    assign flag_z  = s2_q.z;
    assign flag_c  = s2_q.c;
    assign done    = s2_q.done;
    assign busy    = s1_q.vld;

endmodule

// File: rtl/fracmul8_unit_chk.sv
module fracmul8_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] op_a,
    input logic [2:0]   mode,
    input logic [W-1:0] prod_lo,
    input logic [W-1:0] prod_hi,
    input logic         flag_z,
    input logic         flag_c,
    input logic         done,
    input logic         busy
);

    p_done_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !busy, 2));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ##1 !done);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_lo) && $stable(prod_hi) && $stable(flag_z) && $stable(flag_c)));

    p_frac_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mode[2], 2)) |-> !prod_lo[0]);

    p_zero_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op_a, 2) == '0)) |-> (flag_z && !flag_c));

endmodule

bind fracmul8_unit fracmul8_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .mode    (mode),
    .prod_lo (prod_lo),
    .prod_hi (prod_hi),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .done    (done),
    .busy    (busy)
);

// File: tb/fracmul8_unit_tb.sv
module fracmul8_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [2:0] mode = '0;
    logic [7:0] prod_lo, prod_hi;
    logic       flag_z, flag_c, done, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fracmul8_unit u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .mode    (mode),
        .prod_lo (prod_lo),
        .prod_hi (prod_hi),
        .flag_z  (flag_z),
        .flag_c  (flag_c),
        .done    (done),
        .busy    (busy)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model: the unshifted 16-bit product for the given mode.
    function automatic logic [15:0] raw_prod(logic [7:0] a, logic [7:0] b, logic [2:0] m);
        int av, bv, p;
        case (m[1:0])
            2'b01: begin av = int'($signed(a)); bv = int'($signed(b)); end
            2'b10: begin av = int'($signed(a)); bv = int'(b); end
            default: begin av = int'(a); bv = int'(b); end
        endcase
        p = av * bv;
        return p[15:0];
    endfunction

    function automatic logic [15:0] fin_prod(logic [7:0] a, logic [7:0] b, logic [2:0] m);
        logic [15:0] r;
        r = raw_prod(a, b, m);
        return m[2] ? {r[14:0], 1'b0} : r;
    endfunction

    task automatic chk_result(string req, logic [7:0] a, logic [7:0] b, logic [2:0] m);
        logic [15:0] e;
        e = fin_prod(a, b, m);
        chk(req, "product", {prod_hi, prod_lo}, e);
        chk("R6", "flag_c", flag_c, raw_prod(a, b, m)[15]);
        chk("R7", "flag_z", flag_z, e == 16'h0);
    endtask

    task automatic run_op(string req, logic [7:0] a, logic [7:0] b, logic [2:0] m);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b; mode = m;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy mid", busy, 1'b1);
        chk("R8", "done early", done, 1'b0);
        @(negedge clk);
        chk("R8", "done", done, 1'b1);
        chk_result(req, a, b, m);
        @(negedge clk);
        chk("R8", "done width", done, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "done", done, 1'b0);
        chk("R1", "product", {prod_hi, prod_lo}, 16'h0);
        chk("R1", "flags", {flag_z, flag_c}, 2'b00);
    endtask

    task automatic t_unsigned();
        run_op("R2", 8'h0C, 8'h0D, 3'b000);
        run_op("R2", 8'hFF, 8'hFF, 3'b000);
        run_op("R5", 8'hFF, 8'hFF, 3'b100);
        run_op("R5", 8'h40, 8'h40, 3'b100);
    endtask

    task automatic t_signed();
        run_op("R3", 8'hFF, 8'hFF, 3'b001);
        run_op("R3", 8'h80, 8'h7F, 3'b001);
        run_op("R3", 8'h80, 8'h80, 3'b001);
        run_op("R5", 8'h80, 8'h80, 3'b101);
        run_op("R5", 8'hC0, 8'h40, 3'b101);
    endtask

    task automatic t_mixed();
        run_op("R4", 8'hFF, 8'hFF, 3'b010);
        run_op("R4", 8'h80, 8'hFF, 3'b010);
        run_op("R4", 8'h7F, 8'h80, 3'b010);
        run_op("R5", 8'h80, 8'hFF, 3'b110);
        run_op("R5", 8'hFF, 8'hFF, 3'b011);
        run_op("R5", 8'hFF, 8'hFF, 3'b111);
    endtask

    task automatic t_flags();
        run_op("R7", 8'h00, 8'h55, 3'b001);
        run_op("R7", 8'hA5, 8'h00, 3'b110);
        run_op("R6", 8'h81, 8'h02, 3'b100);
    endtask

    task automatic t_busy();
        @(negedge clk);
        start = 1'b1; op_a = 8'h11; op_b = 8'h22; mode = 3'b000;
        @(negedge clk);
        op_a = 8'h33; op_b = 8'h44;      // start held while busy
        @(negedge clk);
        start = 1'b0;
        chk("R9", "done first", done, 1'b1);
        chk_result("R9", 8'h11, 8'h22, 3'b000);
        @(negedge clk);
        chk("R9", "ignored start no done", done, 1'b0);
        chk("R9", "ignored start keeps result", {prod_hi, prod_lo}, fin_prod(8'h11, 8'h22, 3'b000));
        @(negedge clk);
        chk("R9", "ignored start no late done", done, 1'b0);
        // Back-to-back: new request on the done cycle.
        start = 1'b1; op_a = 8'h9C; op_b = 8'h07; mode = 3'b001;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R8", "done a", done, 1'b1);
        chk_result("R3", 8'h9C, 8'h07, 3'b001);
        start = 1'b1; op_a = 8'hE0; op_b = 8'h90; mode = 3'b110;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "taken on done busy", busy, 1'b1);
        chk("R9", "no done between", done, 1'b0);
        @(negedge clk);
        chk("R9", "done b", done, 1'b1);
        chk_result("R9", 8'hE0, 8'h90, 3'b110);
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [15:0] keep;
        run_op("R10", 8'h5A, 8'h3C, 3'b010);
        keep = fin_prod(8'h5A, 8'h3C, 3'b010);
        op_a = 8'h00; op_b = 8'hFF; mode = 3'b101;
        repeat (3) @(negedge clk);
        chk("R10", "product held", {prod_hi, prod_lo}, keep);
        chk("R10", "flags held", {flag_z, flag_c}, {1'b0, raw_prod(8'h5A, 8'h3C, 3'b010)[15]});
        // Operands change right after capture.
        start = 1'b1; op_a = 8'hB7; op_b = 8'h6E; mode = 3'b101;
        @(negedge clk);
        start = 1'b0; op_a = 8'h00; op_b = 8'h01; mode = 3'b000;
        @(negedge clk);
        chk("R11", "done", done, 1'b1);
        chk_result("R11", 8'hB7, 8'h6E, 3'b101);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_unsigned();
        t_signed();
        t_mixed();
        t_flags();
        t_busy();
        t_hold();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule